// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block holds the pending interrupt flags of up to 32 priority slots and chooses the one request the CPU should service next. Each slot has a fixed priority equal to its index and a 16-bit word in a vector table at the top of the address space. The vector word address is `TABLE_BASE + 2 * priority`, so slot 31 maps to 0xFFFE and slot 0 to 0xFFC0. Peripherals raise a slot's flag with a one-cycle set strobe. Software can drop a flag with a one-cycle clear strobe.

Maskable slots need both the global enable and their own per-slot enable. The nonmaskable slot (30) needs only its per-slot enable. The reset slot (31) needs no enable at all. Every cycle the arbiter registers a grant made of a valid bit, a 5-bit priority and a vector address, and the CPU sequencer samples it when it raises its acknowledge strobe. An acknowledged slot whose vector serves a single source has its flag cleared in the same edge, and a one-cycle clear pulse for that slot goes back to the peripheral. A slot whose vector is shared keeps its flag, so the handler must find and clear the source itself.

Top module: `vec_irq_arbiter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `grant_valid` is 0 and `clr_pulse` is 0, and no flag is pending.
- R2: When `grant_valid` is 1, `grant_vec` equals 0xFFC0 + 2 × `grant_prio`, so priority 31 gives 0xFFFE and priority 30 gives 0xFFFC.
- R3: When several slots are eligible, the grant names the one with the highest index.
- R4: A maskable slot (index below 30) is eligible only when `gie` is 1 and its bit in `slot_en` is 1.
- R5: Slot 30 (nonmaskable) is eligible when its `slot_en` bit is 1, whatever `gie` is. Slot 31 (reset) is eligible whenever it is pending, whatever `gie` and `slot_en` are.
- R6: A flag set while its slot is disabled stays pending, and it is granted once the enables allow it.
- R7: When `ack` is high with `grant_valid` 1 and the granted slot is single-source (its bit in `SOLE_MASK` is 1), that flag is cleared at the same edge. `clr_pulse` is then one-hot on that slot for exactly the next cycle.
- R8: A slot whose `SOLE_MASK` bit is 0 is not cleared by `ack` and gets no `clr_pulse`. Only a `flag_swclr` strobe clears it.
- R9: A `flag_set` strobe in the same cycle as an auto-clear or a software clear of the same slot wins, and the flag stays pending.
- R10: A slot whose `USED_MASK` bit is 0 never becomes pending, whatever its `flag_set` input does.
- R11: The grant is registered. A change in flags or enables shows up on `grant_valid`, `grant_prio` and `grant_vec` after one clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | 32 | One-cycle strobe per slot that sets its pending flag |
| flag_swclr | input | 32 | One-cycle strobe per slot that clears its pending flag from software |
| slot_en | input | 32 | Per-slot enable |
| gie | input | 1 | Global enable for maskable slots |
| ack | input | 1 | CPU sequencer acknowledge; samples the current grant |
| grant_valid | output | 1 | A request is eligible |
| grant_prio | output | 5 | Priority (slot index) of the granted request |
| grant_vec | output | 16 | Word address of the granted slot's vector |
| clr_pulse | output | 32 | One-cycle clear pulse for an acknowledged single-source slot |

## Verification
The table-driven part applies one set of pending flags, enables and `gie` at a time:
- a lone maskable request, which shows the vector mapping;
- three maskable requests together, which shows that the highest index wins;
- the same three with `gie` low, which shows global masking;
- the nonmaskable slot with a higher-priority pending request, with `gie` low;
- the reset slot with every enable low;
- a higher slot whose own enable is off, which shows per-slot gating;
- a set strobe on an unused slot;
- a shared slot racing a lower one.

The directed tests cover the corner cases:
- a request held across a disabled window;
- acknowledge of a single-source slot and of a shared slot;
- set strobes that arrive in the same edge as an auto-clear or a software clear;
- the one-edge latency of the registered grant.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   // Word address of a slot's vector in a table of 16-bit words
   function automatic logic [15:0] slot_vec(input logic [15:0] base, input logic [4:0] prio);
      return base + {10'd0, prio, 1'b0};
   endfunction
endpackage

// File: rtl/irqv_flag_bank.sv
module irqv_flag_bank #(
   parameter int          NSLOT     = 32,
   parameter logic [31:0] USED_MASK = 32'hFFFF_FFFF,
   parameter logic [31:0] SOLE_MASK = 32'h0,
   localparam int         PW        = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] set_i,
   input  logic [NSLOT-1:0] swclr_i,
   input  logic             ack_hit_i,
   input  logic [PW-1:0]    ack_idx_i,
   output logic [NSLOT-1:0] flags_o,
   output logic [NSLOT-1:0] clr_pulse_o
);
   logic [NSLOT-1:0] set_m;

   for (genvar i = 0; i < NSLOT; i++) begin : g_slot
      if (USED_MASK[i]) begin : g_live
         logic auto_clr;
         assign auto_clr = ack_hit_i && (ack_idx_i == PW'(i)) && SOLE_MASK[i];
         assign set_m[i] = set_i[i];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags_o[i]     <= 1'b0;
               clr_pulse_o[i] <= 1'b0;
            end else begin
               // a set strobe overrides any clear in the same edge
               flags_o[i]     <= set_i[i] | (flags_o[i] & ~auto_clr & ~swclr_i[i]);
               clr_pulse_o[i] <= auto_clr;
            end
         end
      end else begin : g_tied
         assign flags_o[i]     = 1'b0;
         assign clr_pulse_o[i] = 1'b0;
         assign set_m[i]       = 1'b0;
      end
   end

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_m) |=> ((flags_o & $past(set_m)) == $past(set_m)));
   // R10
   unused_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_o & ~USED_MASK[NSLOT-1:0]) == '0);
   // R7
   clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_pulse_o));
   // R8
   shared_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse_o & ~SOLE_MASK[NSLOT-1:0]) == '0);
endmodule

// File: rtl/irqv_gate.sv
module irqv_gate #(
   parameter int NSLOT    = 32,
   parameter int RST_SLOT = 31,
   parameter int NMI_SLOT = 30
) (
   input  logic [NSLOT-1:0] flags_i,
   input  logic [NSLOT-1:0] en_i,
   input  logic             gie_i,
   output logic [NSLOT-1:0] elig_o
);
   for (genvar i = 0; i < NSLOT; i++) begin : g_gate
      if (i == RST_SLOT) begin : g_rst
         assign elig_o[i] = flags_i[i];
      end else if (i == NMI_SLOT) begin : g_nmi
         assign elig_o[i] = flags_i[i] & en_i[i];
      end else begin : g_mask
         assign elig_o[i] = flags_i[i] & en_i[i] & gie_i;
      end
   end
endmodule

// File: rtl/irqv_pick.sv
module irqv_pick #(
   parameter int NSLOT = 32,
   localparam int PW   = $clog2(NSLOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSLOT-1:0] elig_i,
   output logic             any_o,
   output logic [PW-1:0]    idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NSLOT; i++) begin
         if (elig_i[i]) idx_o = PW'(i);
      end
   end
   assign any_o = |elig_i;

   // R3
   top_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> ((elig_i >> idx_o) == NSLOT'(1)));
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
   parameter int          NSLOT      = 32,
   parameter int          ADDR_W     = 16,
   parameter logic [15:0] TABLE_BASE = 16'hFFC0,
   parameter int          RST_SLOT   = 31,
   parameter int          NMI_SLOT   = 30,
   parameter logic [31:0] USED_MASK  = 32'hC73C_0000,
   parameter logic [31:0] SOLE_MASK  = 32'h0620_0000,
   localparam int         PW         = $clog2(NSLOT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSLOT-1:0]  flag_set,
   input  logic [NSLOT-1:0]  flag_swclr,
   input  logic [NSLOT-1:0]  slot_en,
   input  logic              gie,
   input  logic              ack,
   output logic              grant_valid,
   output logic [PW-1:0]     grant_prio,
   output logic [ADDR_W-1:0] grant_vec,
   output logic [NSLOT-1:0]  clr_pulse
);
   import irqv_pkg::*;

   initial begin
      assert (NSLOT == 32) else $error("NSLOT must be 32");
      assert (ADDR_W == 16) else $error("ADDR_W must be 16");
      assert (RST_SLOT == NSLOT-1) else $error("reset slot must be the top slot");
      assert (NMI_SLOT < RST_SLOT) else $error("nonmaskable slot must sit below reset");
      assert ((32'(TABLE_BASE) + 2*NSLOT) <= 32'h1_0000) else $error("table overruns address space");
   end

   logic [NSLOT-1:0] flags, elig;
   logic             any;
   logic [PW-1:0]    win;
   logic             ack_hit;

   assign ack_hit = ack & grant_valid;

   irqv_flag_bank #(.NSLOT(NSLOT), .USED_MASK(USED_MASK), .SOLE_MASK(SOLE_MASK)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set), .swclr_i(flag_swclr),
      .ack_hit_i(ack_hit), .ack_idx_i(grant_prio),
      .flags_o(flags), .clr_pulse_o(clr_pulse));

   irqv_gate #(.NSLOT(NSLOT), .RST_SLOT(RST_SLOT), .NMI_SLOT(NMI_SLOT)) u_gate (
      .flags_i(flags), .en_i(slot_en), .gie_i(gie), .elig_o(elig));

   irqv_pick #(.NSLOT(NSLOT)) u_pick (
      .clk(clk), .rst_n(rst_n), .elig_i(elig), .any_o(any), .idx_o(win));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_valid <= 1'b0;
         grant_prio  <= '0;
         grant_vec   <= '0;
      end else begin
         grant_valid <= any;
         grant_prio  <= win;
         grant_vec   <= any ? slot_vec(TABLE_BASE, win) : '0;
      end
   end

   // R2
   vec_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> (grant_vec[0] == 1'b0 && grant_vec >= TABLE_BASE));
   // R4
   mask_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && 32'(grant_prio) < NMI_SLOT) |-> $past(gie));
   // R1
   reset_idle_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> (!grant_valid && clr_pulse == '0));
endmodule

// File: tb/vec_irq_arbiter_tb.sv
module vec_irq_arbiter_tb;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] flag_set = 0, flag_swclr = 0, slot_en = 0;
   logic        gie = 0, ack = 0;
   logic        grant_valid;
   logic [4:0]  grant_prio;
   logic [15:0] grant_vec;
   logic [31:0] clr_pulse;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   vec_irq_arbiter u_dut (.clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_swclr(flag_swclr),
      .slot_en(slot_en), .gie(gie), .ack(ack), .grant_valid(grant_valid),
      .grant_prio(grant_prio), .grant_vec(grant_vec), .clr_pulse(clr_pulse));

   // {set, slot_en, gie, exp_valid, exp_prio}
   localparam logic [70:0] TBL [9] = '{
      {32'h0200_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd25},  // R2 lone request
      {32'h0224_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd25},  // R3 highest wins
      {32'h0224_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 5'd0 },  // R4 gie low
      {32'h4400_0000, 32'hFFFF_FFFF, 1'b0, 1'b1, 5'd30},  // R5 nmi without gie
      {32'hC000_0000, 32'h0000_0000, 1'b0, 1'b1, 5'd31},  // R5 reset ignores enables
      {32'h0420_0000, 32'h0020_0000, 1'b1, 1'b1, 5'd21},  // R4 slot enable off
      {32'h0000_0020, 32'hFFFF_FFFF, 1'b1, 1'b0, 5'd0 },  // R10 unused slot
      {32'h0110_0000, 32'hFFFF_FFFF, 1'b1, 1'b1, 5'd24},  // R3 shared vs lower
      {32'h4000_0000, 32'h0000_0000, 1'b1, 1'b0, 5'd0 }   // R5 nmi needs its enable
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      // R1 reset state, with set strobes active during reset
      flag_set = 32'hFFFF_FFFF;
      repeat (3) tick();
      chk("R1 valid in reset", 32'(grant_valid), 0);
      chk("R1 pulse in reset", clr_pulse, 0);
      flag_set = 0;
      rst_n = 1;
      tick();
      chk("R1 valid after reset", 32'(grant_valid), 0);
      slot_en = 32'hFFFF_FFFF; gie = 1;
      tick(); tick();
      chk("R1 no flag left pending", 32'(grant_valid), 0);

      // table walk
      for (int k = 0; k < 9; k++) begin
         flag_swclr = 32'hFFFF_FFFF; flag_set = 0;
         tick();
         flag_swclr = 0;
         flag_set = TBL[k][70:39]; slot_en = TBL[k][38:7]; gie = TBL[k][6];
         tick();
         flag_set = 0;
         tick();
         chk($sformatf("R3/R4/R5/R10 vec %0d valid", k), 32'(grant_valid), 32'(TBL[k][5]));
         if (TBL[k][5]) begin
            chk($sformatf("R3 vec %0d prio", k), 32'(grant_prio), 32'(TBL[k][4:0]));
            chk($sformatf("R2 vec %0d addr", k), 32'(grant_vec), 32'hFFC0 + 2*32'(TBL[k][4:0]));
         end
      end

      // R6 held while disabled, R11 one-edge latency
      flag_swclr = 32'hFFFF_FFFF; tick(); flag_swclr = 0;
      gie = 0; slot_en = 32'hFFFF_FFFF; flag_set = 32'h0020_0000;
      tick(); flag_set = 0;
      repeat (3) tick();
      chk("R6 masked while gie low", 32'(grant_valid), 0);
      gie = 1;
      #1 chk("R11 no change before edge", 32'(grant_valid), 0);
      tick();
      chk("R6 granted after enable", 32'(grant_valid), 1);
      chk("R6 prio", 32'(grant_prio), 21);

      // R7 auto-clear of single-source slot 21
      ack = 1; tick(); ack = 0;
      chk("R7 clr pulse", clr_pulse, 32'h0020_0000);
      tick();
      chk("R7 flag cleared", 32'(grant_valid), 0);
      chk("R7 pulse one cycle", clr_pulse, 0);

      // R8 shared slot 24 survives ack
      flag_set = 32'h0100_0000; tick(); flag_set = 0; tick();
      chk("R8 shared granted", 32'(grant_prio), 24);
      ack = 1; tick(); ack = 0;
      chk("R8 no pulse", clr_pulse, 0);
      tick(); tick();
      chk("R8 still pending", 32'(grant_valid), 1);
      flag_swclr = 32'h0100_0000; tick(); flag_swclr = 0; tick();
      chk("R8 software clear", 32'(grant_valid), 0);

      // R9 set wins over auto-clear (slot 25)
      flag_set = 32'h0200_0000; tick(); flag_set = 0; tick();
      ack = 1; flag_set = 32'h0200_0000; tick(); ack = 0; flag_set = 0;
      tick();
      chk("R9 stays after ack+set", 32'(grant_valid), 1);
      chk("R9 prio", 32'(grant_prio), 25);
      // R9 set wins over software clear
      flag_swclr = 32'h0200_0000; flag_set = 32'h0200_0000; tick();
      flag_swclr = 0; flag_set = 0; tick(); tick();
      chk("R9 stays after swclr+set", 32'(grant_valid), 1);

      done = 1;
      summary();
   end
endmodule